// File: doc/BRIEF.md
# Multiplexed external bus address decoder with bank registers

This block sits on an 8-bit microcontroller external memory bus where one byte-wide port carries first the low address and then the data. A separate port carries the high address for the whole cycle. The block captures the address as the address strobe falls. It then turns the 16-bit address into two active-low selects: one for a peripheral interface chip and one for a shared flash/RAM device. It also holds two bank registers, whose values drive the upper address lines of the memory device.

Software writes the bank registers with ordinary external data writes and can read them back over the same multiplexed port. The block runs on its own system clock, which is not related to the bus timing. All bus strobes are therefore synchronised before they are used. A write takes effect when the write strobe is released, and it uses the byte that was on the bus while the strobe was low.

Top module: `xbus_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, both bank registers clear to 0, both selects go high (inactive) and the block stops driving `ad_io`.
- R2: The address used for decoding is `{hi_addr_i, ad_io}` as sampled when the synchronised `ale_i` falls. Later changes of `ad_io` within the same cycle, such as the data byte, do not alter which register or select is addressed.
- R3: A write cycle to address 0xC004 loads `ram_bank_o` with data bits [1:0].
- R4: A write cycle to address 0xC005 loads `flash_bank_o` with data bits [2:0].
- R5: A bank register keeps its old value while `wr_n_i` is low. The new value appears within 3 clock edges after `wr_n_i` rises.
- R6: `periph_cs_n_o` goes low during a read or write strobe for addresses 0xC000 to 0xC003, and is high at every other time.
- R7: `mem_cs_n_o` goes low during a read or write strobe for any address whose high byte is not 0xC0, and is high at all other times, including for the bank register addresses.
- R8: A read cycle to 0xC004 or 0xC005 drives `ad_io` with the matching bank value, zero-extended to 8 bits, while `rd_n_i` is low.
- R9: `ad_io` is released (high impedance) whenever `rd_n_i` is high or the captured address is not 0xC004 or 0xC005.
- R10: Write cycles to any address other than 0xC004 and 0xC005 leave both bank registers unchanged. This includes 0xC003, 0xC006 and addresses outside the 0xC0 page.
- R11: `aux_o` is held low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_io | inout | 8 | Multiplexed low address / data bus |
| hi_addr_i | input | 8 | High address byte |
| ale_i | input | 1 | Address latch strobe, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| aux_o | output | 1 | Spare output, held low |
| periph_cs_n_o | output | 1 | Peripheral chip select, active low |
| ram_bank_o | output | 2 | RAM bank register value |
| mem_cs_n_o | output | 1 | Flash/RAM device select, active low |
| flash_bank_o | output | 3 | Flash bank register value |

## Verification
Every strobe passes through two synchroniser flops before the logic sees it. The selects are registered after that, so they follow a port strobe edge by 3 clock edges. A bank update lands 3 edges after `wr_n_i` rises, and read data reaches `ad_io` 2 edges after `rd_n_i` falls. The bench changes inputs and samples outputs on the falling clock edge. It holds each strobe for at least 5 cycles before sampling, and waits 6 cycles after a release before checking the bank values. This places every sample well past the latest edge at which its result is due.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus decoder.
// Assumes an 8-bit multiplexed bus with a separate 8-bit high address byte.
package xbus_pkg;

    localparam int BYTE_W = 8;

    // Captured 16-bit bus address, high byte first
    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } bus_addr_t;

    // Decoded target of the captured address
    typedef enum logic [2:0] {
        RGN_NONE      = 3'd0,
        RGN_PERIPH    = 3'd1,
        RGN_RAMBANK   = 3'd2,
        RGN_FLASHBANK = 3'd3,
        RGN_MEMORY    = 3'd4
    } region_e;

endpackage

// File: rtl/xbus_sync.sv
// Multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2; the reset value is the idle level of the input.
module xbus_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the async level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xbus_front.sv
// Bus front end: synchronises the three strobes and finds their edges.
// It captures the address when the address strobe falls and holds the data
// byte while the write strobe is low.
// Assumes the address stays on the bus for SYNC_STAGES+2 cycles after the
// strobe falls, and the data stays for the same time after the write strobe rises.
module xbus_front
    import xbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              wr_n_i,
    input  logic              rd_n_i,
    input  logic [BYTE_W-1:0] ad_i,
    input  logic [BYTE_W-1:0] hi_i,
    output bus_addr_t         addr_o,
    output logic              wr_commit_o,
    output logic              wr_act_o,
    output logic              rd_act_o,
    output logic [BYTE_W-1:0] wdata_o
);

    localparam int NSIG = 3;
    localparam int IDX_ALE = 2;
    localparam int IDX_WR  = 1;
    localparam int IDX_RD  = 0;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b011;

    logic [NSIG-1:0] raw_lvl;
    logic [NSIG-1:0] sync_lvl;
    logic [NSIG-1:0] prev_lvl;
    logic            ale_fall;

    assign raw_lvl = {ale_i, wr_n_i, rd_n_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        xbus_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(IDLE_LVL[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lvl[g]),
            .q    (sync_lvl[g])
        );
    end

    // Keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= IDLE_LVL;
        else        prev_lvl <= sync_lvl;
    end

    assign ale_fall    = prev_lvl[IDX_ALE] & ~sync_lvl[IDX_ALE];
    assign wr_commit_o = ~prev_lvl[IDX_WR] & sync_lvl[IDX_WR];
    assign wr_act_o    = ~sync_lvl[IDX_WR];
    assign rd_act_o    = ~sync_lvl[IDX_RD];

    // Capture the full address on the falling address strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_o <= '0;
        else if (ale_fall) addr_o <= '{hi: hi_i, lo: ad_i};
    end

    // Track the data byte for as long as the write strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n)        wdata_o <= '0;
        else if (wr_act_o) wdata_o <= ad_i;
    end

endmodule

// File: rtl/xbus_decode.sv
// Address decoder: classifies the captured address and drives registered
// active-low selects while a synchronised read or write strobe is active.
// Assumes the captured address is stable during the strobe.
module xbus_decode
    import xbus_pkg::*;
#(
    parameter logic [7:0] REG_PAGE       = 8'hC0,
    parameter logic [7:0] PERIPH_LAST    = 8'h03,
    parameter logic [7:0] RAM_BANK_OFS   = 8'h04,
    parameter logic [7:0] FLASH_BANK_OFS = 8'h05
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_addr_t addr_i,
    input  logic      wr_act_i,
    input  logic      rd_act_i,
    output region_e   region_o,
    output logic      periph_cs_n_o,
    output logic      mem_cs_n_o
);

    logic strobe;

    assign strobe = wr_act_i | rd_act_i;

    // Map the captured address onto a target region
    always_comb begin
        if (addr_i.hi != REG_PAGE)           region_o = RGN_MEMORY;
        else if (addr_i.lo <= PERIPH_LAST)   region_o = RGN_PERIPH;
        else if (addr_i.lo == RAM_BANK_OFS)  region_o = RGN_RAMBANK;
        else if (addr_i.lo == FLASH_BANK_OFS) region_o = RGN_FLASHBANK;
        else                                 region_o = RGN_NONE;
    end

    // Register the selects so that the pins are glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_cs_n_o <= 1'b1;
            mem_cs_n_o    <= 1'b1;
        end else begin
            periph_cs_n_o <= ~(strobe && (region_o == RGN_PERIPH));
            mem_cs_n_o    <= ~(strobe && (region_o == RGN_MEMORY));
        end
    end

endmodule

// File: rtl/xbus_banks.sv
// Bank register file: two bank registers loaded on a write commit, plus the
// read-back path onto the multiplexed bus.
// Assumes RAM_W and FLASH_W are no wider than a byte.
module xbus_banks
    import xbus_pkg::*;
#(
    parameter int RAM_W   = 2,
    parameter int FLASH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  region_e            region_i,
    input  logic               wr_commit_i,
    input  logic               rd_act_i,
    input  logic [BYTE_W-1:0]  wdata_i,
    output logic [RAM_W-1:0]   ram_bank_o,
    output logic [FLASH_W-1:0] flash_bank_o,
    output logic [BYTE_W-1:0]  rdata_o,
    output logic               drive_en_o
);

    localparam int RAM_PAD   = BYTE_W - RAM_W;
    localparam int FLASH_PAD = BYTE_W - FLASH_W;

    logic hit_ram;
    logic hit_flash;

    assign hit_ram   = (region_i == RGN_RAMBANK);
    assign hit_flash = (region_i == RGN_FLASHBANK);

    // Load the RAM bank register when a write to it completes
    always_ff @(posedge clk) begin
        if (!rst_n)                      ram_bank_o <= '0;
        else if (wr_commit_i && hit_ram) ram_bank_o <= wdata_i[RAM_W-1:0];
    end

    // Load the flash bank register when a write to it completes
    always_ff @(posedge clk) begin
        if (!rst_n)                        flash_bank_o <= '0;
        else if (wr_commit_i && hit_flash) flash_bank_o <= wdata_i[FLASH_W-1:0];
    end

    // Select the zero-extended value to return on a read
    always_comb begin
        if (hit_flash) rdata_o = {{FLASH_PAD{1'b0}}, flash_bank_o};
        else           rdata_o = {{RAM_PAD{1'b0}}, ram_bank_o};
    end

    assign drive_en_o = rd_act_i && (hit_ram || hit_flash);

endmodule

// File: rtl/xbus_decoder.sv
// Top of the external bus decoder: front end, address decoder and bank
// registers, plus the tristate driver onto the multiplexed bus.
// Assumes the system clock is not related to the bus strobes, which are
// synchronised inside.
module xbus_decoder
    import xbus_pkg::*;
#(
    parameter int         SYNC_STAGES    = 2,
    parameter int         RAM_BANK_W     = 2,
    parameter int         FLASH_BANK_W   = 3,
    parameter logic [7:0] REG_PAGE       = 8'hC0,
    parameter logic [7:0] PERIPH_LAST    = 8'h03,
    parameter logic [7:0] RAM_BANK_OFS   = 8'h04,
    parameter logic [7:0] FLASH_BANK_OFS = 8'h05
) (
    input  logic                    clk,
    input  logic                    rst_n,
    inout  wire  [7:0]              ad_io,
    input  logic [7:0]              hi_addr_i,
    input  logic                    ale_i,
    input  logic                    wr_n_i,
    input  logic                    rd_n_i,
    output logic                    aux_o,
    output logic                    periph_cs_n_o,
    output logic [RAM_BANK_W-1:0]   ram_bank_o,
    output logic                    mem_cs_n_o,
    output logic [FLASH_BANK_W-1:0] flash_bank_o
);

    bus_addr_t         cap_addr;
    logic              wr_commit;
    logic              wr_act;
    logic              rd_act;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rdata;
    logic              drive_en;
    region_e           region;

    xbus_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale_i      (ale_i),
        .wr_n_i     (wr_n_i),
        .rd_n_i     (rd_n_i),
        .ad_i       (ad_io),
        .hi_i       (hi_addr_i),
        .addr_o     (cap_addr),
        .wr_commit_o(wr_commit),
        .wr_act_o   (wr_act),
        .rd_act_o   (rd_act),
        .wdata_o    (wdata)
    );

    xbus_decode #(
        .REG_PAGE      (REG_PAGE),
        .PERIPH_LAST   (PERIPH_LAST),
        .RAM_BANK_OFS  (RAM_BANK_OFS),
        .FLASH_BANK_OFS(FLASH_BANK_OFS)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (cap_addr),
        .wr_act_i     (wr_act),
        .rd_act_i     (rd_act),
        .region_o     (region),
        .periph_cs_n_o(periph_cs_n_o),
        .mem_cs_n_o   (mem_cs_n_o)
    );

    xbus_banks #(
        .RAM_W  (RAM_BANK_W),
        .FLASH_W(FLASH_BANK_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .region_i    (region),
        .wr_commit_i (wr_commit),
        .rd_act_i    (rd_act),
        .wdata_i     (wdata),
        .ram_bank_o  (ram_bank_o),
        .flash_bank_o(flash_bank_o),
        .rdata_o     (rdata),
        .drive_en_o  (drive_en)
    );

    // Drive the bus only during a bank register read
    assign ad_io = drive_en ? rdata : {BYTE_W{1'bz}};

    assign aux_o = 1'b0;

endmodule

// File: rtl/xbus_decoder_chk.sv
// Checker for xbus_decoder: timing relations between bus strobes and outputs.
// Assumes a two-flop synchroniser for the read-drive check.
module xbus_decoder_chk #(
    parameter int SYNC_STAGES  = 2,
    parameter int RAM_BANK_W   = 2,
    parameter int FLASH_BANK_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_n_i,
    input logic                    rd_n_i,
    input logic                    aux_o,
    input logic                    periph_cs_n_o,
    input logic                    mem_cs_n_o,
    input logic [RAM_BANK_W-1:0]   ram_bank_o,
    input logic [FLASH_BANK_W-1:0] flash_bank_o,
    input logic                    drive_en
);

    logic [2:0] warm;
    logic       ready;

    // Count cycles since reset so that no check looks back past it
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= '0;
        else if (warm != 3'd7)  warm <= warm + 3'd1;
    end

    assign ready = (warm >= 3'd4);

    always_comb begin
        assert_aux_low_R11: assert (aux_o == 1'b0);
    end

    assert_idle_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_n_i && rd_n_i && $past(wr_n_i, 1) && $past(rd_n_i, 1)
         && $past(wr_n_i, 2) && $past(rd_n_i, 2)
         && $past(wr_n_i, 3) && $past(rd_n_i, 3))
        |-> (periph_cs_n_o && mem_cs_n_o));

    assert_periph_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !periph_cs_n_o) |-> (!$past(rd_n_i, 3) || !$past(wr_n_i, 3)));

    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(wr_n_i, 3)) |-> ($stable(ram_bank_o) && $stable(flash_bank_o)));

    if (SYNC_STAGES == 2) begin : g_drive_chk
        assert_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && drive_en) |-> !$past(rd_n_i, 2));
    end

endmodule

bind xbus_decoder xbus_decoder_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .RAM_BANK_W  (RAM_BANK_W),
    .FLASH_BANK_W(FLASH_BANK_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_n_i       (wr_n_i),
    .rd_n_i       (rd_n_i),
    .aux_o        (aux_o),
    .periph_cs_n_o(periph_cs_n_o),
    .mem_cs_n_o   (mem_cs_n_o),
    .ram_bank_o   (ram_bank_o),
    .flash_bank_o (flash_bank_o),
    .drive_en     (drive_en)
);

// File: tb/tb_xbus_decoder.sv
module tb_xbus_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hi = 8'h00;
    logic       ale = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] tb_ad = 8'h00;
    logic       tb_oe = 1'b0;
    wire  [7:0] ad_bus;
    logic       aux, pcs_n, mcs_n;
    logic [1:0] ram_bank;
    logic [2:0] flash_bank;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // values seen in the middle of a strobe / after it
    logic       seen_pcs, seen_mcs;
    logic [1:0] mid_ram;
    logic [2:0] mid_flash;
    logic [7:0] seen_rd, seen_after;

    always #4 clk = ~clk;

    assign ad_bus = tb_oe ? tb_ad : 8'hzz;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (ad_bus[i]);
    end

    xbus_decoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_io        (ad_bus),
        .hi_addr_i    (hi),
        .ale_i        (ale),
        .wr_n_i       (wr_n),
        .rd_n_i       (rd_n),
        .aux_o        (aux),
        .periph_cs_n_o(pcs_n),
        .ram_bank_o   (ram_bank),
        .mem_cs_n_o   (mcs_n),
        .flash_bank_o (flash_bank)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic addr_phase(input logic [7:0] h, input logic [7:0] l);
        @(negedge clk);
        hi = h; tb_ad = l; tb_oe = 1'b1; ale = 1'b1;
        repeat (3) @(negedge clk);
        ale = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] h, input logic [7:0] l, input logic [7:0] d);
        addr_phase(h, l);
        tb_ad = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (5) @(negedge clk);
        seen_pcs = pcs_n; seen_mcs = mcs_n; mid_ram = ram_bank; mid_flash = flash_bank;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        tb_oe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] h, input logic [7:0] l);
        addr_phase(h, l);
        tb_oe = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b0;
        repeat (5) @(negedge clk);
        seen_rd = ad_bus; seen_pcs = pcs_n; seen_mcs = mcs_n;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        seen_after = ad_bus;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 ram bank", ram_bank, 0);
        check("R1 flash bank", flash_bank, 0);
        check("R1 periph cs", pcs_n, 1);
        check("R1 mem cs", mcs_n, 1);
        check("R9 bus released in reset", ad_bus, 8'hFF);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ram_bank();
        bus_write(8'hC0, 8'h04, 8'h43);
        check("R5 ram bank held during write", mid_ram, 0);
        check("R3 ram bank = 0x43[1:0]", ram_bank, 3);
        check("R6 no periph cs for 0xC004", seen_pcs, 1);
        check("R7 no mem cs for 0xC004", seen_mcs, 1);
        bus_write(8'hC0, 8'h04, 8'h06);
        check("R3 ram bank = 0x06[1:0]", ram_bank, 2);
    endtask

    task automatic t_flash_bank();
        bus_write(8'hC0, 8'h05, 8'h55);
        check("R5 flash bank held during write", mid_flash, 0);
        check("R4 flash bank = 0x55[2:0]", flash_bank, 5);
        bus_write(8'hC0, 8'h05, 8'hFA);
        check("R4 flash bank = 0xFA[2:0]", flash_bank, 2);
        check("R10 ram bank kept by flash write", ram_bank, 2);
    endtask

    task automatic t_addr_capture();
        // data bytes equal to the other register's low address
        bus_write(8'hC0, 8'h04, 8'h05);
        check("R2 write went to ram bank", ram_bank, 1);
        check("R2 flash bank untouched", flash_bank, 2);
        bus_write(8'hC0, 8'h05, 8'h04);
        check("R2 write went to flash bank", flash_bank, 4);
        check("R2 ram bank untouched", ram_bank, 1);
    endtask

    task automatic t_periph();
        bus_write(8'hC0, 8'h03, 8'h53);
        check("R6 periph cs on write 0xC003", seen_pcs, 0);
        check("R7 no mem cs for 0xC003", seen_mcs, 1);
        check("R10 ram kept after 0xC003", ram_bank, 1);
        check("R10 flash kept after 0xC003", flash_bank, 4);
        check("R6 periph cs released", pcs_n, 1);
        bus_read(8'hC0, 8'h00);
        check("R6 periph cs on read 0xC000", seen_pcs, 0);
        check("R9 no drive for 0xC000", seen_rd, 8'hFF);
        bus_write(8'hC0, 8'h06, 8'hFF);
        check("R6 no periph cs for 0xC006", seen_pcs, 1);
        check("R7 no mem cs for 0xC006", seen_mcs, 1);
        check("R10 ram kept after 0xC006", ram_bank, 1);
        check("R10 flash kept after 0xC006", flash_bank, 4);
    endtask

    task automatic t_memory();
        bus_write(8'h55, 8'h55, 8'h43);
        check("R7 mem cs on write 0x5555", seen_mcs, 0);
        check("R6 no periph cs for 0x5555", seen_pcs, 1);
        check("R7 mem cs released", mcs_n, 1);
        check("R10 ram kept after 0x5555", ram_bank, 1);
        bus_write(8'h80, 8'h05, 8'hD5);
        check("R7 mem cs on write 0x8005", seen_mcs, 0);
        check("R10 flash kept after 0x8005", flash_bank, 4);
        bus_write(8'h57, 8'hAB, 8'h4B);
        check("R7 mem cs on write 0x57AB", seen_mcs, 0);
        bus_read(8'hF5, 8'hAE);
        check("R7 mem cs on read 0xF5AE", seen_mcs, 0);
        check("R9 no drive for 0xF5AE", seen_rd, 8'hFF);
    endtask

    task automatic t_readback();
        bus_read(8'hC0, 8'h04);
        check("R8 read ram bank", seen_rd, 8'h01);
        check("R9 released after ram read", seen_after, 8'hFF);
        bus_read(8'hC0, 8'h05);
        check("R8 read flash bank", seen_rd, 8'h04);
        check("R9 released after flash read", seen_after, 8'hFF);
        check("R11 aux low", aux, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_ram_bank();
        t_flash_bank();
        t_addr_capture();
        t_periph();
        t_memory();
        t_readback();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule